// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for a Memory Device

This block is the test access port of a memory device. A tester drives it through four serial pins: a test clock, a mode select, serial data in and serial data out. It runs the standard sixteen-state controller. It holds a 3-bit instruction register and three data registers: a 32-bit identification register, a 1-bit bypass register, and a boundary register. The length of the boundary register is set by parameters. The active instruction chooses which of these registers is shifted between serial in and serial out.

The boundary register has one cell for each device input pin and one cell for each device output pin. The output cells have a separate update stage, and during external test that stage drives the pins. The block sits between the device core and its pads. It passes the functional output data and enables through in normal operation. It replaces the data with the update stage under external test. Under the high-impedance sample instruction it forces every output enable low. Two control outputs report the current data-select and enable-override state to the pad ring.

Top module: `scan_tap_sram`

## Requirements
- R1: After power-up or any reset, the identification instruction (code 001) is active, `tdo_oe` is low, and the pads are in functional mode: `pad_out` = `func_out` and `pad_oe` = `func_oe`.
- R2: Holding `tms` high for five rising `tck` edges brings the controller to Test-Logic-Reset from any state, and the identification instruction becomes active again.
- R3: In Capture-IR the instruction shift register loads binary 001, so the first three bits shifted out are 1, 0, 0.
- R4: Under instruction 001, Capture-DR loads the identification value `ID_VAL`, whose bit 0 is 1. Shift-DR then shifts it out least significant bit first.
- R5: Under instruction 111 the 1-bit bypass register is in the path. It captures 0, and each bit shifted out is the `tdi` bit from one shift earlier.
- R6: The unused codes 011, 101 and 110 behave exactly like 111, and the pads stay in functional mode.
- R7: Under instruction 100 (sample/preload), Capture-DR loads `pin_in` into boundary bits [NUM_IN-1:0] and the value presented on `pad_out` into bits [NUM_IN+NUM_OUT-1:NUM_IN]. Bit 0 is shifted out first. Update-DR copies the shifted bits [NUM_IN+NUM_OUT-1:NUM_IN] into the update stage. The pads stay functional.
- R8: Under instruction 000 (external test), `pad_out` equals the update stage, every `pad_oe` bit is 1, and Capture-DR and Update-DR behave as in R7.
- R9: Under instruction 010 (high-impedance sample), every `pad_oe` bit is 0 and `pad_out` carries `func_out`. Capture-DR and Update-DR behave as in R7.
- R10: The update stage changes only on the falling `tck` edge in Update-DR. It is stable while bits are shifting.
- R11: `tdo` changes only on falling `tck` edges. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.
- R12: Driving `trst_n` low forces Test-Logic-Reset, the identification instruction and a low `tdo_oe` at once, without waiting for a clock edge.
- R13: A newly shifted instruction takes effect only on the falling `tck` edge in Update-IR. The previous instruction stays in force while the new one is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| pin_in | input | NUM_IN | Device input pin values |
| func_out | input | NUM_OUT | Functional output data from the core |
| func_oe | input | NUM_OUT | Functional output enables from the core |
| pad_out | output | NUM_OUT | Data to the output pads |
| pad_oe | output | NUM_OUT | Enables to the output pads |
| ctl_hiz | output | 1 | High when all output enables are forced off |
| ctl_test_sel | output | 1 | High when the pad data comes from the update stage |

## Verification
The bench targets the edge-timing corners.

- **Instruction timing:** it checks that an instruction being shifted does not switch the pads before Update-IR. A design that decoded the shift register directly would start driving test data part way through an instruction scan.
- **Update-stage stability:** it checks that the pads under external test hold their value through a whole data shift. A design without a separate update stage would ripple the shifting bits onto the pins.
- **Unused codes and forced return:** it sends every unused code and the five-ones reset path. A design that mis-decoded these would lengthen the chain or leave a stale instruction behind.
- **Asynchronous reset:** it asserts `trst_n` in the middle of Shift-DR. A design that reset synchronously would keep `tdo_oe` high and keep the pads in test mode until the next clock.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

   localparam int OP_W = 3;

   typedef enum logic [3:0] {
      TS_RESET    = 4'd0,
      TS_IDLE     = 4'd1,
      TS_DR_SEL   = 4'd2,
      TS_DR_CAP   = 4'd3,
      TS_DR_SHIFT = 4'd4,
      TS_DR_EXIT1 = 4'd5,
      TS_DR_PAUSE = 4'd6,
      TS_DR_EXIT2 = 4'd7,
      TS_DR_UPD   = 4'd8,
      TS_IR_SEL   = 4'd9,
      TS_IR_CAP   = 4'd10,
      TS_IR_SHIFT = 4'd11,
      TS_IR_EXIT1 = 4'd12,
      TS_IR_PAUSE = 4'd13,
      TS_IR_EXIT2 = 4'd14,
      TS_IR_UPD   = 4'd15
   } tap_state_t;

   typedef enum logic [OP_W-1:0] {
      OP_EXTEST  = 3'b000,
      OP_IDCODE  = 3'b001,
      OP_SAMPLEZ = 3'b010,
      OP_RSV3    = 3'b011,
      OP_SAMPLE  = 3'b100,
      OP_RSV5    = 3'b101,
      OP_RSV6    = 3'b110,
      OP_BYPASS  = 3'b111
   } tap_op_t;

   typedef enum logic [1:0] {
      PATH_BYP = 2'd0,
      PATH_ID  = 2'd1,
      PATH_BSR = 2'd2
   } dr_path_t;

   typedef struct packed {
      dr_path_t path;
      logic     force_hiz;
      logic     test_drive;
   } op_dec_t;

   function automatic op_dec_t decode_op(tap_op_t op);
      op_dec_t d;
      d = '{path: PATH_BYP, force_hiz: 1'b0, test_drive: 1'b0};
      case (op)
         OP_EXTEST:  begin d.path = PATH_BSR; d.test_drive = 1'b1; end
         OP_IDCODE:  d.path = PATH_ID;
         OP_SAMPLEZ: begin d.path = PATH_BSR; d.force_hiz = 1'b1; end
         OP_SAMPLE:  d.path = PATH_BSR;
         default:    d.path = PATH_BYP;
      endcase
      return d;
   endfunction

   function automatic tap_state_t next_state(tap_state_t s, logic m);
      tap_state_t n;
      case (s)
         TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
         TS_IDLE:     n = m ? TS_DR_SEL   : TS_IDLE;
         TS_DR_SEL:   n = m ? TS_IR_SEL   : TS_DR_CAP;
         TS_DR_CAP:   n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
         TS_DR_SHIFT: n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
         TS_DR_EXIT1: n = m ? TS_DR_UPD   : TS_DR_PAUSE;
         TS_DR_PAUSE: n = m ? TS_DR_EXIT2 : TS_DR_PAUSE;
         TS_DR_EXIT2: n = m ? TS_DR_UPD   : TS_DR_SHIFT;
         TS_DR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
         TS_IR_SEL:   n = m ? TS_RESET    : TS_IR_CAP;
         TS_IR_CAP:   n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
         TS_IR_SHIFT: n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
         TS_IR_EXIT1: n = m ? TS_IR_UPD   : TS_IR_PAUSE;
         TS_IR_PAUSE: n = m ? TS_IR_EXIT2 : TS_IR_PAUSE;
         TS_IR_EXIT2: n = m ? TS_IR_UPD   : TS_IR_SHIFT;
         default:     n = m ? TS_DR_SEL   : TS_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= TS_RESET;
      else        state <= next_state(state, tms);
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import scan_tap_pkg::*;
(
   input  logic            tck,
   input  logic            rst_n,
   input  tap_state_t      state,
   input  logic            tdi,
   output logic [OP_W-1:0] ir_sh,
   output tap_op_t         op_q
);

   localparam logic [OP_W-1:0] CAP_PAT = {{(OP_W-2){1'b0}}, 2'b01};

   // shift stage: rising edge
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_sh <= CAP_PAT;
      end else begin
         case (state)
            TS_IR_CAP:   ir_sh <= CAP_PAT;
            TS_IR_SHIFT: ir_sh <= {tdi, ir_sh[OP_W-1:1]};
            default:     ir_sh <= ir_sh;
         endcase
      end
   end

   // active instruction: falling edge
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)                 op_q <= OP_IDCODE;
      else if (state == TS_RESET) op_q <= OP_IDCODE;
      else if (state == TS_IR_UPD) op_q <= tap_op_t'(ir_sh);
   end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import scan_tap_pkg::*;
#(
   parameter int               NUM_IN  = 8,
   parameter int               NUM_OUT = 8,
   parameter int               ID_W    = 32,
   parameter logic [ID_W-1:0]  ID_VAL  = 32'h2B73_9A4D
)(
   input  logic               tck,
   input  logic               rst_n,
   input  tap_state_t         state,
   input  dr_path_t           path,
   input  logic               tdi,
   input  logic [NUM_IN-1:0]  pin_in,
   input  logic [NUM_OUT-1:0] pad_val,
   output logic               dr_tdo,
   output logic [ID_W-1:0]    id_sh,
   output logic [NUM_OUT-1:0] bsr_upd
);

   localparam int BSR_W = NUM_IN + NUM_OUT;

   logic [BSR_W-1:0] bsr_sh;
   logic             byp_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         bsr_sh <= '0;
         id_sh  <= '0;
         byp_q  <= 1'b0;
      end else if (state == TS_DR_CAP) begin
         case (path)
            PATH_BSR: bsr_sh <= {pad_val, pin_in};
            PATH_ID:  id_sh  <= ID_VAL;
            default:  byp_q  <= 1'b0;
         endcase
      end else if (state == TS_DR_SHIFT) begin
         case (path)
            PATH_BSR: bsr_sh <= {tdi, bsr_sh[BSR_W-1:1]};
            PATH_ID:  id_sh  <= {tdi, id_sh[ID_W-1:1]};
            default:  byp_q  <= tdi;
         endcase
      end
   end

   // update stage for the output cells, falling edge
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)
         bsr_upd <= '0;
      else if (state == TS_DR_UPD && path == PATH_BSR)
         bsr_upd <= bsr_sh[BSR_W-1:NUM_IN];
   end

   always_comb begin
      case (path)
         PATH_BSR: dr_tdo = bsr_sh[0];
         PATH_ID:  dr_tdo = id_sh[0];
         default:  dr_tdo = byp_q;
      endcase
   end

endmodule

// File: rtl/scan_tap_sram.sv
module scan_tap_sram
   import scan_tap_pkg::*;
#(
   parameter int               NUM_IN  = 8,
   parameter int               NUM_OUT = 8,
   parameter int               ID_W    = 32,
   parameter logic [ID_W-1:0]  ID_VAL  = 32'h2B73_9A4D
)(
   input  logic               tck,
   input  logic               tms,
   input  logic               tdi,
   input  logic               trst_n,
   output logic               tdo,
   output logic               tdo_oe,
   input  logic [NUM_IN-1:0]  pin_in,
   input  logic [NUM_OUT-1:0] func_out,
   input  logic [NUM_OUT-1:0] func_oe,
   output logic [NUM_OUT-1:0] pad_out,
   output logic [NUM_OUT-1:0] pad_oe,
   output logic               ctl_hiz,
   output logic               ctl_test_sel
);

   if (NUM_IN < 1) begin : g_chk_in
      $error("NUM_IN must be at least 1");
   end
   if (NUM_OUT < 1) begin : g_chk_out
      $error("NUM_OUT must be at least 1");
   end
   if (ID_W < 2) begin : g_chk_idw
      $error("ID_W must be at least 2");
   end
   if (ID_VAL[0] != 1'b1) begin : g_chk_idlsb
      $error("ID_VAL bit 0 must be 1");
   end

   tap_state_t         state;
   tap_op_t            op_q;
   logic [OP_W-1:0]    ir_sh;
   op_dec_t            dec;
   logic               dr_tdo;
   logic [ID_W-1:0]    id_sh;
   logic [NUM_OUT-1:0] bsr_upd;
   logic               tdo_q;
   logic               tdo_oe_q;

   tap_fsm u_fsm (
      .tck   (tck),
      .rst_n (trst_n),
      .tms   (tms),
      .state (state)
   );

   tap_ir u_ir (
      .tck   (tck),
      .rst_n (trst_n),
      .state (state),
      .tdi   (tdi),
      .ir_sh (ir_sh),
      .op_q  (op_q)
   );

   assign dec          = decode_op(op_q);
   assign ctl_hiz      = dec.force_hiz;
   assign ctl_test_sel = dec.test_drive;

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_pad
      assign pad_out[g] = dec.test_drive ? bsr_upd[g] : func_out[g];
      assign pad_oe[g]  = dec.force_hiz  ? 1'b0 :
                          (dec.test_drive ? 1'b1 : func_oe[g]);
   end

   tap_dr #(
      .NUM_IN  (NUM_IN),
      .NUM_OUT (NUM_OUT),
      .ID_W    (ID_W),
      .ID_VAL  (ID_VAL)
   ) u_dr (
      .tck     (tck),
      .rst_n   (trst_n),
      .state   (state),
      .path    (dec.path),
      .tdi     (tdi),
      .pin_in  (pin_in),
      .pad_val (pad_out),
      .dr_tdo  (dr_tdo),
      .id_sh   (id_sh),
      .bsr_upd (bsr_upd)
   );

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q    <= 1'b0;
         tdo_oe_q <= 1'b0;
      end else begin
         tdo_oe_q <= (state == TS_IR_SHIFT) || (state == TS_DR_SHIFT);
         if (state == TS_IR_SHIFT)      tdo_q <= ir_sh[0];
         else if (state == TS_DR_SHIFT) tdo_q <= dr_tdo;
      end
   end

   assign tdo    = tdo_q;
   assign tdo_oe = tdo_oe_q;

endmodule

// File: rtl/scan_tap_sram_chk.sv
module scan_tap_sram_chk
   import scan_tap_pkg::*;
#(
   parameter int               NUM_OUT = 8,
   parameter int               ID_W    = 32,
   parameter logic [ID_W-1:0]  ID_VAL  = 32'h2B73_9A4D
)(
   input logic               tck,
   input logic               trst_n,
   input logic               tms,
   input tap_state_t         state,
   input tap_op_t            op_q,
   input logic [OP_W-1:0]    ir_sh,
   input logic [ID_W-1:0]    id_sh,
   input logic [NUM_OUT-1:0] bsr_upd,
   input logic [NUM_OUT-1:0] pad_out,
   input logic [NUM_OUT-1:0] pad_oe,
   input logic               tdo_oe
);

   assert_tdo_en_R11: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == ((state == TS_IR_SHIFT) || (state == TS_DR_SHIFT)));

   assert_five_ones_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == TS_RESET));

   assert_reset_op_R12: assert property (@(posedge tck) disable iff (!trst_n)
      ($past(state) == TS_RESET) |-> (op_q == OP_IDCODE));

   assert_ir_cap_R3: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_IR_CAP) |=> (ir_sh[1:0] == 2'b01));

   assert_id_cap_R4: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_DR_CAP && op_q == OP_IDCODE) |=> (id_sh == ID_VAL));

   assert_extest_R8: assert property (@(posedge tck) disable iff (!trst_n)
      (op_q == OP_EXTEST) |-> (pad_out == bsr_upd && pad_oe == '1));

   assert_samplez_R9: assert property (@(posedge tck) disable iff (!trst_n)
      (op_q == OP_SAMPLEZ) |-> (pad_oe == '0));

   assert_upd_hold_R10: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_DR_SHIFT) |=> $stable(bsr_upd));

   assert_ir_change_R13: assert property (@(posedge tck) disable iff (!trst_n)
      !$stable(op_q) |-> (state == TS_IR_UPD || state == TS_RESET));

endmodule

bind scan_tap_sram scan_tap_sram_chk #(
   .NUM_OUT (NUM_OUT),
   .ID_W    (ID_W),
   .ID_VAL  (ID_VAL)
) u_chk (
   .tck     (tck),
   .trst_n  (trst_n),
   .tms     (tms),
   .state   (state),
   .op_q    (op_q),
   .ir_sh   (ir_sh),
   .id_sh   (id_sh),
   .bsr_upd (bsr_upd),
   .pad_out (pad_out),
   .pad_oe  (pad_oe),
   .tdo_oe  (tdo_oe)
);

// File: tb/test_scan_tap_sram.sv
`timescale 1ns/1ps
module test_scan_tap_sram;

   localparam int NI = 8;
   localparam int NO = 8;
   localparam int BW = NI + NO;
   localparam logic [31:0] IDV = 32'h2B73_9A4D;
   localparam logic [2:0] C_EXT = 3'b000, C_ID = 3'b001, C_HZ = 3'b010,
                          C_SMP = 3'b100, C_BYP = 3'b111;

   logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
   logic tdo, tdo_oe, ctl_hiz, ctl_test_sel;
   logic [NI-1:0] pin_in = '0;
   logic [NO-1:0] func_out = '0, func_oe = '0;
   logic [NO-1:0] pad_out, pad_oe;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [NO-1:0] upd_m = '0;

   always #4 tck = ~tck;

   scan_tap_sram #(.NUM_IN(NI), .NUM_OUT(NO), .ID_W(32), .ID_VAL(IDV)) i_scan_tap_sram (
      .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo), .tdo_oe(tdo_oe),
      .pin_in(pin_in), .func_out(func_out), .func_oe(func_oe),
      .pad_out(pad_out), .pad_oe(pad_oe), .ctl_hiz(ctl_hiz), .ctl_test_sel(ctl_test_sel));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic int dr_len(input logic [2:0] op);
      if (op == C_ID) return 32;
      if (op == C_EXT || op == C_HZ || op == C_SMP) return BW;
      return 1;
   endfunction

   function automatic logic [NO-1:0] exp_pad(input logic [2:0] op);
      return (op == C_EXT) ? upd_m : func_out;
   endfunction

   function automatic logic [NO-1:0] exp_oe(input logic [2:0] op);
      if (op == C_HZ) return '0;
      if (op == C_EXT) return '1;
      return func_oe;
   endfunction

   task automatic step(input logic m, input logic d, output logic o_do, output logic o_oe);
      @(negedge tck); #1;
      o_do = tdo; o_oe = tdo_oe;
      tms = m; tdi = d;
   endtask

   task automatic go(input logic m);
      logic a, b;
      step(m, 1'b0, a, b);
   endtask

   // from Run-Test/Idle back to Run-Test/Idle
   task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap, output logic mid_sel);
      logic a, b;
      go(1); go(1); go(0); go(0);
      for (int i = 0; i < 3; i++) begin
         step(i == 2, op[i], a, b);
         cap[i] = a;
         if (i == 2) mid_sel = ctl_test_sel;
      end
      go(1); go(0);
   endtask

   task automatic scan_dr(input logic [63:0] din, input int n, input bit hold_chk,
                          output logic [63:0] dout, output bit oe_ok);
      logic a, b;
      logic [NO-1:0] hold;
      bit held;
      dout = '0; oe_ok = 1; held = 1;
      go(1); go(0); go(0);
      hold = pad_out;
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], a, b);
         dout[i] = a;
         if (!b) oe_ok = 0;
         if (pad_out !== hold) held = 0;
      end
      if (hold_chk) chk(held, "R10 pads held during Shift-DR", {56'd0, pad_out}, {56'd0, hold});
      go(1); go(0);
   endtask

   function automatic logic [63:0] mask(input int n);
      return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
   endfunction

   logic [2:0] cap;
   logic mid;
   logic [63:0] dout, din, expv;
   bit oe_ok;
   logic a0, b0;

   initial begin
      void'($urandom(32'd20250));
      pin_in = 8'hC3; func_out = 8'h5A; func_oe = 8'hF0;
      repeat (3) @(negedge tck);
      #1 trst_n = 1'b1;
      #1;
      chk(tdo_oe == 1'b0, "R1 tdo_oe after reset", {63'd0, tdo_oe}, 64'd0);
      chk(pad_out == func_out && pad_oe == func_oe && !ctl_test_sel && !ctl_hiz,
          "R1 pads functional after reset", {48'd0, pad_out, pad_oe}, {48'd0, func_out, func_oe});
      step(0, 0, a0, b0);
      step(0, 0, a0, b0);
      chk(b0 == 1'b0, "R11 tdo_oe low in Run-Test/Idle", {63'd0, b0}, 64'd0);

      // R4 / R1: identification scan with default instruction
      din = 64'h0000_0000_A5A5_0F0F;
      scan_dr(din, 32, 0, dout, oe_ok);
      chk(dout[31:0] == IDV, "R4 R1 identification value", dout, {32'd0, IDV});
      chk(oe_ok, "R11 tdo_oe high in Shift-DR", {63'd0, oe_ok}, 64'd1);

      // R3 capture pattern, R5 bypass
      scan_ir(C_BYP, cap, mid);
      chk(cap == 3'b001, "R3 capture-IR pattern", {61'd0, cap}, 64'd1);
      din = 64'h0000_0000_0000_00B6;
      scan_dr(din, 9, 0, dout, oe_ok);
      expv = (din << 1) & mask(9);
      chk(dout == expv, "R5 bypass one-bit delay", dout, expv);

      // R2 five TMS-high edges
      repeat (5) go(1);
      go(0);
      scan_dr(64'd0, 32, 0, dout, oe_ok);
      chk(dout[31:0] == IDV, "R2 five ones restore identification", dout, {32'd0, IDV});

      // R6 unused codes
      foreach (cap[k]) begin end
      for (int r = 0; r < 3; r++) begin
         logic [2:0] rc;
         rc = (r == 0) ? 3'b011 : ((r == 1) ? 3'b101 : 3'b110);
         scan_ir(rc, cap, mid);
         chk(pad_out == func_out && pad_oe == func_oe, "R6 unused code pads functional",
             {48'd0, pad_out, pad_oe}, {48'd0, func_out, func_oe});
         din = 64'h0000_0000_0000_0000 | (64'h1D3 ^ r);
         scan_dr(din, 10, 0, dout, oe_ok);
         expv = (din << 1) & mask(10);
         chk(dout == expv, "R6 unused code acts as bypass", dout, expv);
      end

      // R7 sample / preload
      pin_in = 8'h96; func_out = 8'h3C; func_oe = 8'h0F;
      scan_ir(C_SMP, cap, mid);
      chk(pad_out == func_out && pad_oe == func_oe, "R7 sample pads functional",
          {48'd0, pad_out, pad_oe}, {48'd0, func_out, func_oe});
      din = {48'd0, 8'hE1, 8'h00};
      scan_dr(din, BW, 0, dout, oe_ok);
      expv = {48'd0, func_out, pin_in};
      chk(dout == expv, "R7 sample capture", dout, expv);
      upd_m = din[BW-1:NI];

      // R13 / R8 external test
      scan_ir(C_EXT, cap, mid);
      chk(mid == 1'b0, "R13 no test drive while IR shifting", {63'd0, mid}, 64'd0);
      chk(pad_out == upd_m && pad_oe == '1, "R8 extest drives preload",
          {48'd0, pad_out, pad_oe}, {48'd0, upd_m, 8'hFF});
      pin_in = 8'h41;
      din = {48'd0, 8'h7E, 8'h00};
      scan_dr(din, BW, 1, dout, oe_ok);
      expv = {48'd0, upd_m, pin_in};
      chk(dout == expv, "R8 extest capture", dout, expv);
      upd_m = din[BW-1:NI];
      chk(pad_out == upd_m, "R10 update stage loaded at Update-DR", {56'd0, pad_out}, {56'd0, upd_m});

      // R9 high-impedance sample
      func_out = 8'hA7; func_oe = 8'hFF; pin_in = 8'h1E;
      scan_ir(C_HZ, cap, mid);
      chk(mid == 1'b1, "R13 previous instruction held during IR shift", {63'd0, mid}, 64'd1);
      chk(pad_oe == '0 && ctl_hiz, "R9 outputs forced off", {56'd0, pad_oe}, 64'd0);
      chk(pad_out == func_out, "R9 data functional", {56'd0, pad_out}, {56'd0, func_out});
      din = {48'd0, 8'h33, 8'h00};
      scan_dr(din, BW, 0, dout, oe_ok);
      expv = {48'd0, func_out, pin_in};
      chk(dout == expv, "R9 capture inputs", dout, expv);
      upd_m = din[BW-1:NI];

      // R12 asynchronous reset in Shift-DR
      scan_ir(C_EXT, cap, mid);
      go(1); go(0); go(0);
      @(negedge tck); #1;
      tms = 1'b1; trst_n = 1'b0;
      #1;
      chk(tdo_oe == 1'b0, "R12 tdo_oe off at once", {63'd0, tdo_oe}, 64'd0);
      chk(!ctl_test_sel && pad_oe == func_oe, "R12 pads functional at once",
          {55'd0, ctl_test_sel, pad_oe}, {56'd0, func_oe});
      @(negedge tck); #1 trst_n = 1'b1;
      go(0);
      scan_dr(64'd0, 32, 0, dout, oe_ok);
      chk(dout[31:0] == IDV, "R12 identification after reset", dout, {32'd0, IDV});
      upd_m = '0;

      // constrained random
      for (int it = 0; it < 24; it++) begin
         logic [2:0] op;
         int n;
         op = 3'($urandom % 8);
         pin_in = NI'($urandom); func_out = NO'($urandom); func_oe = NO'($urandom);
         scan_ir(op, cap, mid);
         chk(cap == 3'b001, "R3 random capture-IR", {61'd0, cap}, 64'd1);
         chk(pad_out == exp_pad(op) && pad_oe == exp_oe(op), "R6 R7 R8 R9 random pad mode",
             {48'd0, pad_out, pad_oe}, {48'd0, exp_pad(op), exp_oe(op)});
         n = dr_len(op);
         din = {$urandom, $urandom};
         scan_dr(din, n, 0, dout, oe_ok);
         if (n == 32)      expv = {32'd0, IDV};
         else if (n == 1)  expv = (din << 1) & mask(1);
         else              expv = {48'd0, exp_pad(op), pin_in};
         chk((dout & mask(n)) == expv, "R4 R5 R7 random DR scan", dout & mask(n), expv);
         if (n == BW) upd_m = din[BW-1:NI];
         chk(pad_out == exp_pad(op), "R10 random update result", {56'd0, pad_out}, {56'd0, exp_pad(op)});
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(64'd200000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule